// File: doc/BRIEF.md
# Synchronized Start and Trigger Controller

This block decides the clock cycle in which waveform generation begins on a set of output channels. A start can come from two places: a software start command issued inside the fabric clock domain, or a trigger line on the backplane that several modules share so that they all begin together. A select input picks the source. A rising edge on the chosen source latches a run condition. The per-channel enables are sampled at that moment, and the result drives one run output per channel.

The run condition is held by a two-state machine. The states are `ST_IDLE` and `ST_RUN`. The transition `ST_IDLE -> ST_RUN` (start accepted) occurs on a start edge from the selected source when at least one channel is enabled and trigger-reset is low. The transition `ST_RUN -> ST_IDLE` (cleared) is taken on trigger-reset. The transition `ST_RUN -> ST_IDLE` (all stopped) is taken when a stop command removes the last running channel. The active-low system reset puts the machine in `ST_IDLE` from any state.

Two further functions are included. First, a registered trigger output follows a control bit. Second, the level of a trigger connector is synchronized and made readable. The backplane trigger and the connector input each pass through a multi-flop synchronizer.

Top module: `sync_start_ctl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `run_out` is all zero, `start_latched` is 0 and `trig_out` is 0. Asserting `rst_n` low while running clears them at once.
- R2: With `src_sel`=0, a 0-to-1 change on `sw_start` sampled at a clock edge sets `run_out` and `start_latched` at that same edge. Edges on `bp_trig` have no effect in this mode.
- R3: With `src_sel`=1, a rising edge on `bp_trig` sets `run_out` at the third clock edge after the new level is applied, which is SYNC_STAGES+1 edges. Edges on `sw_start` have no effect in this mode.
- R4: A start is recognized on a rising edge only. The latch holds after the source returns low. A source that is still high after the latch is cleared does not latch again.
- R5: At the start edge, `run_out[i]` takes the value of `chan_en[i]`. All enabled channels rise in the same cycle. A start edge with `chan_en` all zero leaves the block idle.
- R6: `trig_rst`=1 clears `run_out` and `start_latched` at the next edge. This takes priority over a start edge in the same cycle.
- R7: `stop_cmd`=1 clears the channels whose `stop_sel` bit is 1 at the next edge and leaves the others running. When no channel is left running, the block returns to idle and accepts a new start.
- R8: `trig_out` equals `trig_out_ctl` delayed by one clock.
- R9: `trig_in_lvl` shows the level of `trig_in_pin` SYNC_STAGES clock edges after it changes.
- R10: While running, changes to `chan_en` do not affect `run_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low system reset, asynchronous assert |
| sw_start | input | 1 | Software start command, in the clock domain |
| bp_trig | input | 1 | Shared backplane trigger, asynchronous |
| src_sel | input | 1 | Start source: 1 = backplane, 0 = software |
| trig_rst | input | 1 | Clears the latched start |
| stop_cmd | input | 1 | Stop strobe |
| stop_sel | input | NCH | Channels the stop applies to |
| chan_en | input | NCH | Per-channel start enables |
| trig_out_ctl | input | 1 | Control value for the trigger output |
| trig_in_pin | input | 1 | Trigger connector level, asynchronous |
| run_out | output | NCH | Per-channel run outputs |
| start_latched | output | 1 | High while the start condition is latched |
| trig_out | output | 1 | Registered trigger output |
| trig_in_lvl | output | 1 | Synchronized connector level |

## Verification
The bench builds the block with its defaults: NCH=2 and SYNC_STAGES=2. With two channels the bench can show the cases that matter: both outputs rising together, one channel left disabled, a partial stop that leaves one channel running, and a final stop that returns the block to idle. A two-stage synchronizer fixes the backplane start latency at three edges and the connector readback latency at two. Each of these latencies is checked one edge early (still low) and exactly on time (high).

// File: rtl/sync_start_pkg.sv
package sync_start_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/start_sync_chain.sv
module start_sync_chain #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/start_edge_det.sv
module start_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/start_run_fsm.sv
module start_run_fsm
    import sync_start_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_evt,
    input  logic           trig_rst,
    input  logic           stop_cmd,
    input  logic [NCH-1:0] stop_sel,
    input  logic [NCH-1:0] chan_en,
    output logic [NCH-1:0] run_out,
    output logic           started
);
    run_state_e     state, nxt;
    logic [NCH-1:0] ch_run;
    logic [NCH-1:0] remaining;

    assign remaining = ch_run & ~stop_sel;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!trig_rst && start_evt && (|chan_en)) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (trig_rst)                           nxt = ST_IDLE;
                else if (stop_cmd && (remaining == '0)) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_run <= '0;
        end else if (trig_rst) begin
            ch_run <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (nxt == ST_RUN) ch_run <= chan_en;
                ST_RUN:  if (stop_cmd)      ch_run <= remaining;
                default: ch_run <= '0;
            endcase
        end
    end

    assign run_out = ch_run;
    assign started = (state == ST_RUN);

    // R6
    trig_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rst |=> (run_out == '0 && !started));

    // R7
    stop_sel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && started && !trig_rst) |=> ((run_out & $past(stop_sel)) == '0));

    // R10
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !trig_rst && !stop_cmd) |=> $stable(run_out));
endmodule

// File: rtl/sync_start_ctl.sv
module sync_start_ctl
    import sync_start_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sw_start,
    input  logic           bp_trig,
    input  logic           src_sel,
    input  logic           trig_rst,
    input  logic           stop_cmd,
    input  logic [NCH-1:0] stop_sel,
    input  logic [NCH-1:0] chan_en,
    input  logic           trig_out_ctl,
    input  logic           trig_in_pin,
    output logic [NCH-1:0] run_out,
    output logic           start_latched,
    output logic           trig_out,
    output logic           trig_in_lvl
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] async_in, synced;
    logic             bp_sync, bp_rise, sw_rise, start_evt;
    logic             trig_out_q;
    logic             past_ok;

    assign async_in = {trig_in_pin, bp_trig};

    start_sync_chain #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(async_in), .q_sync(synced)
    );

    assign bp_sync     = synced[0];
    assign trig_in_lvl = synced[1];

    start_edge_det u_bp_edge (.clk(clk), .rst_n(rst_n), .level(bp_sync),  .rise(bp_rise));
    start_edge_det u_sw_edge (.clk(clk), .rst_n(rst_n), .level(sw_start), .rise(sw_rise));

    assign start_evt = src_sel ? bp_rise : sw_rise;

    start_run_fsm #(.NCH(NCH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .trig_rst(trig_rst),
        .stop_cmd(stop_cmd), .stop_sel(stop_sel), .chan_en(chan_en),
        .run_out(run_out), .started(start_latched)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_out_q <= 1'b0;
        else        trig_out_q <= trig_out_ctl;
    end
    assign trig_out = trig_out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R8
    trig_out_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (trig_out == $past(trig_out_ctl)));

    // R5
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(start_latched)) |->
            (run_out != '0 && (run_out & ~$past(chan_en)) == '0));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (run_out == '0 && !start_latched && !trig_out));
endmodule

// File: tb/sync_start_ctl_bench.sv
module sync_start_ctl_bench;
    localparam int NCH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_start = 0, bp_trig = 0, src_sel = 0, trig_rst = 0, stop_cmd = 0;
    logic [NCH-1:0] stop_sel = '0, chan_en = '0;
    logic trig_out_ctl = 0, trig_in_pin = 0;
    logic [NCH-1:0] run_out;
    logic start_latched, trig_out, trig_in_lvl;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sync_start_ctl #(.NCH(NCH), .SYNC_STAGES(2)) u_sync_start_ctl (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .bp_trig(bp_trig),
        .src_sel(src_sel), .trig_rst(trig_rst), .stop_cmd(stop_cmd),
        .stop_sel(stop_sel), .chan_en(chan_en), .trig_out_ctl(trig_out_ctl),
        .trig_in_pin(trig_in_pin), .run_out(run_out),
        .start_latched(start_latched), .trig_out(trig_out),
        .trig_in_lvl(trig_in_lvl)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edge_s();
        @(posedge clk); #1;
    endtask

    task automatic drv();
        @(negedge clk);
    endtask

    task automatic do_reset();
        drv(); rst_n = 0; sw_start = 0; bp_trig = 0; trig_rst = 0; stop_cmd = 0;
        stop_sel = '0; trig_out_ctl = 0; trig_in_pin = 0; src_sel = 0;
        edge_s(); edge_s();
        drv(); rst_n = 1;
        edge_s();
    endtask

    task automatic clear_latch();
        drv(); trig_rst = 1; sw_start = 0; bp_trig = 0;
        edge_s();
        drv(); trig_rst = 0;
        edge_s(); edge_s(); edge_s();
    endtask

    task automatic t_reset();
        drv(); rst_n = 0; #1;
        check("R1 run in reset", run_out, 0);
        check("R1 latched in reset", start_latched, 0);
        edge_s();
        check("R1 trig_out in reset", trig_out, 0);
        drv(); rst_n = 1;
        edge_s();
        check("R1 run after reset", run_out, 0);
    endtask

    task automatic t_sw_start();
        drv(); src_sel = 0; chan_en = 2'b11; bp_trig = 1;
        edge_s(); edge_s(); edge_s();
        check("R2 bp ignored when sw selected", run_out, 0);
        drv(); sw_start = 1;
        edge_s();
        check("R2 sw start both channels", run_out, 2'b11);
        check("R2 latched", start_latched, 1);
        drv(); sw_start = 0;
        edge_s(); edge_s();
        check("R4 holds after source low", run_out, 2'b11);
        clear_latch();
    endtask

    task automatic t_bp_start();
        drv(); src_sel = 1; chan_en = 2'b01; sw_start = 1;
        edge_s();
        check("R3 sw ignored when bp selected", run_out, 0);
        drv(); sw_start = 0; bp_trig = 1;
        edge_s(); edge_s();
        check("R3 not yet after two edges", run_out, 0);
        edge_s();
        check("R3 bp start on third edge", run_out, 2'b01);
        check("R5 disabled channel stays low", run_out[1], 0);
        clear_latch();
    endtask

    task automatic t_edge_only();
        drv(); src_sel = 0; chan_en = 2'b10; sw_start = 1;
        edge_s();
        check("R4 first edge latches", run_out, 2'b10);
        drv(); trig_rst = 1;
        edge_s();
        check("R6 trig_rst clears", run_out, 0);
        drv(); trig_rst = 0;
        edge_s(); edge_s();
        check("R4 held level does not relatch", start_latched, 0);
        drv(); sw_start = 0;
        edge_s();
    endtask

    task automatic t_no_enable();
        drv(); src_sel = 0; chan_en = 2'b00; sw_start = 1;
        edge_s();
        check("R5 no enable stays idle", start_latched, 0);
        drv(); sw_start = 0;
        edge_s();
    endtask

    task automatic t_clear_priority();
        drv(); src_sel = 0; chan_en = 2'b11; sw_start = 1; trig_rst = 1;
        edge_s();
        check("R6 clear beats start", run_out, 0);
        drv(); trig_rst = 0;
        edge_s();
        check("R6 no late start", start_latched, 0);
        drv(); sw_start = 0;
        edge_s();
    endtask

    task automatic t_stop();
        drv(); src_sel = 0; chan_en = 2'b11; sw_start = 1;
        edge_s();
        drv(); sw_start = 0; chan_en = 2'b00;
        edge_s();
        check("R10 enable change ignored while running", run_out, 2'b11);
        drv(); stop_cmd = 1; stop_sel = 2'b01;
        edge_s();
        check("R7 partial stop", run_out, 2'b10);
        check("R7 still latched", start_latched, 1);
        drv(); stop_sel = 2'b10;
        edge_s();
        check("R7 last stop idles", start_latched, 0);
        drv(); stop_cmd = 0; stop_sel = 0; chan_en = 2'b01; sw_start = 1;
        edge_s();
        check("R7 restart after stop", run_out, 2'b01);
        drv(); sw_start = 0; chan_en = 2'b11; rst_n = 0; #1;
        check("R1 reset while running", run_out, 0);
        drv(); rst_n = 1;
        edge_s();
    endtask

    task automatic t_trig_io();
        drv(); trig_out_ctl = 1; trig_in_pin = 1;
        edge_s();
        check("R8 trig_out one cycle", trig_out, 1);
        check("R9 not yet synced", trig_in_lvl, 0);
        edge_s();
        check("R9 synced after two", trig_in_lvl, 1);
        drv(); trig_out_ctl = 0; trig_in_pin = 0;
        edge_s();
        check("R8 trig_out falls", trig_out, 0);
        edge_s();
        check("R9 falls after two", trig_in_lvl, 0);
    endtask

    initial begin
        t_reset();
        t_sw_start();
        t_bp_start();
        t_edge_only();
        t_no_enable();
        t_clear_priority();
        t_stop();
        t_trig_io();
        do_reset();
        check("R1 idle at end", run_out, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule